// File: doc/BRIEF.md
# PCM Two-Channel Serial Voice Port

This block connects a parallel byte interface to a bit-serial voice line. That line is timed by a bit clock and a frame-sync pulse. Each frame carries two 8-bit channel slots, B1 and B2. A channel-select pin picks which of the two slots the port serves. In that slot the port shifts one byte out on the transmit line and captures one byte from the receive line, most significant bit first.

Configuration pins set four things:
- where the first slot starts relative to frame sync: non-delayed or delayed by one bit;
- whether B2 follows B1 directly or after a two-bit idle gap;
- whether the byte carries only seven data bits;
- whether the received byte is echoed back onto the transmit slot instead of the host byte.

The transmit side is a valid/ready stream. A byte is accepted only in the bit-clock cycle in which a new frame begins. When no byte is offered, the previous byte is sent again.

The receive side cannot apply back-pressure, because the line cannot be stalled. The port presents each byte with a single-cycle valid strobe. The byte stays on `rx_data` until the next byte overwrites it, so the consumer must take it when the strobe is high.

Top module: `pcm_duplex_port`

## Requirements
- R1: Bits are MSB first. The B1 slot occupies the 8 data-bit periods starting at the first data bit of the frame. With `gap_fmt`=0, B2 occupies the 8 periods that immediately follow B1. `ch_sel`=0 selects B1 and 1 selects B2.
- R2: With `gap_fmt`=1, B2 starts 10 bit periods after the first data bit, leaving two idle periods after B1.
- R3: With `early_start`=1, the first data bit is driven in the bit period that begins at the rising `bclk` edge where `fsync` is first sampled high. With `early_start`=0 (delayed timing), it comes one bit period later.
- R4: `txd_oe` is high only during the data bits of the selected slot. When it is high, `txd` carries the slot byte.
- R5: With `seven_bit`=1, `txd_oe` is low during the LSB period of the slot, and bit 0 of the received byte reads as 0 whatever the line carried.
- R6: `rx_valid` is high for exactly one bit-clock cycle, in the bit period after the last slot bit. In that cycle `rx_data` holds the received byte. Each bit is sampled on the falling edge in the middle of its bit period.
- R7: `tx_ready` is high only while `fsync` is high and was low at the previous rising edge, and only when `loop_en`=0. `tx_data` is latched on `tx_valid`&&`tx_ready`. If `tx_valid` is low at the frame start, the previous slot byte is transmitted again.
- R8: With `loop_en`=1, the slot transmits the most recently received byte and ignores `tx_data`. That byte also becomes the held byte used by R7.
- R9: A new `fsync` rise before the frame ends restarts the bit count. The partially received byte produces no `rx_valid`, and the new frame is placed correctly.
- R10: During and after reset, `txd_oe`, `rx_valid` and `tx_ready` are low until a frame sync arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; transmit updates on rise, receive samples on fall |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame-sync pulse, sampled on the rising edge |
| rxd | input | 1 | Serial receive data |
| early_start | input | 1 | 1 = non-delayed frame start, 0 = delayed |
| gap_fmt | input | 1 | 1 = two idle bits between B1 and B2 |
| seven_bit | input | 1 | 1 = only seven MSBs carry data |
| loop_en | input | 1 | 1 = echo the received byte onto the transmit slot |
| ch_sel | input | 1 | 0 = serve B1, 1 = serve B2 |
| tx_data | input | 8 | Byte offered for the next frame |
| tx_valid | input | 1 | `tx_data` is valid |
| tx_ready | output | 1 | Frame start; byte accepted when valid |
| txd | output | 1 | Serial transmit data |
| txd_oe | output | 1 | Drive enable for `txd`; low means high impedance |
| rx_data | output | 8 | Last received slot byte |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_data` |

## Verification
The bench sweeps every combination of timing, gap format, seven-bit mode and channel over several byte patterns. It predicts the slot position and the enable window for each bit period. A one-off slot start would show the byte shifted a bit early or late, or an enable leaking into the gap. A port that ignored seven-bit mode would drive the LSB period or report the line's LSB.

In loopback the bench checks that the echoed byte is the previous frame's capture and that the host byte is not consumed. After loopback it checks that an unserviced frame repeats the held byte.

A frame cut short by an early sync is used to catch a counter that fails to realign. Such a counter would raise a spurious `rx_valid` or misplace the next frame's slot.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  typedef struct packed {
    logic early;
    logic gap;
    logic seven;
    logic loop;
    logic ch;
  } pcm_cfg_t;
endpackage

// File: rtl/pcm_slot_timer.sv
module pcm_slot_timer
  import pcm_pkg::*;
#(
  parameter int W = 8,
  parameter int GAP = 2,
  localparam int CNT_W = $clog2(2 * W + GAP + 2),
  localparam int IDX_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync,
  input  pcm_cfg_t         cfg,
  output logic             fs_rise,
  output logic             cur_act,
  output logic [IDX_W-1:0] cur_idx,
  output logic             nxt_act,
  output logic [IDX_W-1:0] nxt_idx
);
  // count 0 = idle, 1 = lead period, 2 = first data bit
  localparam logic [CNT_W-1:0] V_LAST = CNT_W'(2 * W + GAP + 1);

  logic             fs_q;
  logic [CNT_W-1:0] cnt, cnt_n;

  function automatic logic [CNT_W:0] decode(input logic [CNT_W-1:0] v,
                                            input logic gap, input logic ch);
    logic [CNT_W-1:0] start;
    logic [CNT_W-1:0] rel;
    start = CNT_W'(2);
    if (ch) start = start + (gap ? CNT_W'(W + GAP) : CNT_W'(W));
    rel = v - start;
    decode = {(v >= start) && (rel < CNT_W'(W)), rel};
  endfunction

  assign fs_rise = fsync & ~fs_q;

  always_comb begin
    if (fs_rise) cnt_n = cfg.early ? CNT_W'(2) : CNT_W'(1);
    else if (cnt != '0 && cnt != V_LAST) cnt_n = cnt + CNT_W'(1);
    else cnt_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q <= 1'b0;
      cnt  <= '0;
    end else begin
      fs_q <= fsync;
      cnt  <= cnt_n;
    end
  end

  logic [CNT_W:0] dc, dn;
  assign dc      = decode(cnt, cfg.gap, cfg.ch);
  assign dn      = decode(cnt_n, cfg.gap, cfg.ch);
  assign cur_act = dc[CNT_W];
  assign cur_idx = dc[IDX_W-1:0];
  assign nxt_act = dn[CNT_W];
  assign nxt_idx = dn[IDX_W-1:0];
endmodule

// File: rtl/pcm_tx_serializer.sv
module pcm_tx_serializer #(
  parameter int W = 8,
  localparam int IDX_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fs_rise,
  input  logic             loop,
  input  logic             seven,
  input  logic [W-1:0]     tx_data,
  input  logic             tx_valid,
  input  logic [W-1:0]     loop_byte,
  input  logic             nxt_act,
  input  logic [IDX_W-1:0] nxt_idx,
  output logic             tx_ready,
  output logic             txd,
  output logic             txd_oe
);
  logic [W-1:0]     hold, byte_n;
  logic [IDX_W-1:0] sel;

  assign tx_ready = fs_rise & ~loop;

  always_comb begin
    byte_n = hold;
    if (fs_rise) begin
      if (loop) byte_n = loop_byte;
      else if (tx_valid) byte_n = tx_data;
    end
  end

  assign sel = IDX_W'(W - 1) - nxt_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold   <= '0;
      txd    <= 1'b0;
      txd_oe <= 1'b0;
    end else begin
      hold   <= byte_n;
      txd    <= nxt_act & byte_n[sel];
      txd_oe <= nxt_act & ~(seven && nxt_idx == IDX_W'(W - 1));
    end
  end
endmodule

// File: rtl/pcm_rx_deserializer.sv
module pcm_rx_deserializer #(
  parameter int W = 8,
  localparam int IDX_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd,
  input  logic             seven,
  input  logic             cur_act,
  input  logic [IDX_W-1:0] cur_idx,
  output logic [W-1:0]     rx_data,
  output logic             rx_valid
);
  logic         rx_s;
  logic [W-2:0] sh;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) rx_s <= 1'b0;
    else        rx_s <= rxd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (cur_act) begin
        if (cur_idx == IDX_W'(W - 1)) begin
          rx_data  <= {sh, rx_s & ~seven};
          rx_valid <= 1'b1;
        end else begin
          sh <= {sh[W-3:0], rx_s};
        end
      end
    end
  end
endmodule

// File: rtl/pcm_duplex_port.sv
module pcm_duplex_port
  import pcm_pkg::*;
(
  input  logic       bclk,
  input  logic       rst_n,
  input  logic       fsync,
  input  logic       rxd,
  input  logic       early_start,
  input  logic       gap_fmt,
  input  logic       seven_bit,
  input  logic       loop_en,
  input  logic       ch_sel,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic       txd,
  output logic       txd_oe,
  output logic [7:0] rx_data,
  output logic       rx_valid
);
  localparam int W = 8;
  localparam int GAP = 2;
  localparam int IDX_W = $clog2(W);

  pcm_cfg_t         cfg;
  logic             fs_rise, cur_act, nxt_act;
  logic [IDX_W-1:0] cur_idx, nxt_idx;

  assign cfg = '{early: early_start, gap: gap_fmt, seven: seven_bit,
                 loop: loop_en, ch: ch_sel};

  pcm_slot_timer #(.W(W), .GAP(GAP)) u_timer (
    .clk(bclk), .rst_n(rst_n), .fsync(fsync), .cfg(cfg),
    .fs_rise(fs_rise), .cur_act(cur_act), .cur_idx(cur_idx),
    .nxt_act(nxt_act), .nxt_idx(nxt_idx)
  );

  pcm_tx_serializer #(.W(W)) u_tx (
    .clk(bclk), .rst_n(rst_n), .fs_rise(fs_rise), .loop(cfg.loop),
    .seven(cfg.seven), .tx_data(tx_data), .tx_valid(tx_valid),
    .loop_byte(rx_data), .nxt_act(nxt_act), .nxt_idx(nxt_idx),
    .tx_ready(tx_ready), .txd(txd), .txd_oe(txd_oe)
  );

  pcm_rx_deserializer #(.W(W)) u_rx (
    .clk(bclk), .rst_n(rst_n), .rxd(rxd), .seven(cfg.seven),
    .cur_act(cur_act), .cur_idx(cur_idx),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );
endmodule

// File: rtl/pcm_port_chk.sv
module pcm_port_chk (
  input logic bclk,
  input logic rst_n,
  input logic fsync,
  input logic loop_en,
  input logic tx_ready,
  input logic txd_oe,
  input logic rx_valid
);
  logic seen_sync;
  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n)     seen_sync <= 1'b0;
    else if (fsync) seen_sync <= 1'b1;
  end

  // R6
  valid_pulse_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R7
  ready_sync_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    tx_ready |-> fsync);

  // R8
  loop_ready_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    loop_en |-> !tx_ready);

  // R10
  oe_after_sync_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    (txd_oe || rx_valid) |-> seen_sync);
endmodule

bind pcm_duplex_port pcm_port_chk u_chk (
  .bclk(bclk), .rst_n(rst_n), .fsync(fsync), .loop_en(loop_en),
  .tx_ready(tx_ready), .txd_oe(txd_oe), .rx_valid(rx_valid)
);

// File: tb/sim_pcm_duplex_port.sv
`timescale 1ns/1ps
module sim_pcm_duplex_port;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       fsync = 0, rxd = 0, early_start = 0, gap_fmt = 0, seven_bit = 0;
  logic       loop_en = 0, ch_sel = 0, tx_valid = 0;
  logic [7:0] tx_data = 0;
  logic       tx_ready, txd, txd_oe, rx_valid;
  logic [7:0] rx_data;

  int total = 0, bad = 0;
  logic [7:0] hold_m = 8'h00, last_rx_m = 8'h00;

  always #2.5 clk = ~clk;

  pcm_duplex_port u0 (
    .bclk(clk), .rst_n(rst_n), .fsync(fsync), .rxd(rxd),
    .early_start(early_start), .gap_fmt(gap_fmt), .seven_bit(seven_bit),
    .loop_en(loop_en), .ch_sel(ch_sel), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .txd(txd), .txd_oe(txd_oe),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one frame; K = number of bit periods observed after the sync edge
  task automatic frame(input logic e, input logic f, input logic b7, input logic ch,
                       input logic lp, input logic vld, input logic [7:0] txb,
                       input logic [7:0] rxb, input int K);
    logic [7:0] exp_byte;
    int s;
    exp_byte = lp ? last_rx_m : (vld ? txb : hold_m);
    s = (e ? 0 : 1) + (ch ? (f ? 10 : 8) : 0);
    @(posedge clk); #1;
    early_start = e; gap_fmt = f; seven_bit = b7; ch_sel = ch; loop_en = lp;
    fsync = 1; tx_valid = vld; tx_data = txb; rxd = 0;
    @(negedge clk);
    chk(tx_ready == !lp, lp ? "R8 ready in loopback" : "R7 ready at frame start",
        tx_ready, !lp);
    for (int k = 0; k < K; k++) begin
      int j;
      logic act, exp_oe;
      @(posedge clk); #1;
      fsync = 0; tx_valid = 0; tx_data = 8'hFF;
      j = k - s;
      act = (j >= 0) && (j < 8);
      rxd = act ? rxb[7 - j] : 1'b0;
      @(negedge clk);
      exp_oe = act && !(b7 && j == 7);
      chk(txd_oe == exp_oe, b7 ? "R5 enable window" : (f ? "R2 enable window" : "R4 enable window"),
          txd_oe, exp_oe);
      if (exp_oe)
        chk(txd == exp_byte[7 - j], lp ? "R8 looped bit" : (e ? "R1 tx bit" : "R3 tx bit"),
            txd, exp_byte[7 - j]);
      chk(rx_valid == (k == s + 8), K < 24 ? "R9 no strobe" : "R6 strobe timing",
          rx_valid, k == s + 8);
      if (k == s + 8) begin
        logic [7:0] er;
        er = b7 ? (rxb & 8'hFE) : rxb;
        chk(rx_data == er, b7 ? "R5 rx lsb" : "R6 rx byte", rx_data, er);
        last_rx_m = er;
      end
    end
    hold_m = exp_byte;
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] pats [3];
    pats[0] = 8'hA5; pats[1] = 8'h3C; pats[2] = 8'h81;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk(txd_oe == 0 && rx_valid == 0 && tx_ready == 0, "R10 in reset",
        {txd_oe, rx_valid, tx_ready}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(txd_oe == 0 && rx_valid == 0 && tx_ready == 0, "R10 after reset",
        {txd_oe, rx_valid, tx_ready}, 0);
    for (int c = 0; c < 16; c++)
      for (int p = 0; p < 3; p++) begin
        logic [7:0] tb_, rb_;
        tb_ = pats[p] ^ 8'(c * 17);
        rb_ = {tb_[3:0], tb_[7:4]} ^ 8'h5F;
        frame(c[0], c[1], c[2], c[3], 0, 1, tb_, rb_, 24);
      end
    // R8 loopback: echo previous capture, host byte ignored
    frame(1, 0, 0, 0, 0, 1, 8'h66, 8'h5A, 24);
    frame(1, 0, 0, 1, 1, 1, 8'hFF, 8'hC3, 24);
    frame(0, 1, 0, 1, 1, 1, 8'h00, 8'h11, 24);
    // R7 no valid: the held (looped) byte repeats
    frame(1, 0, 0, 0, 0, 0, 8'hEE, 8'h96, 24);
    frame(0, 0, 0, 1, 0, 0, 8'hEE, 8'h69, 24);
    // R9 early sync cuts a frame mid-slot
    frame(1, 0, 0, 0, 0, 1, 8'hB7, 8'h4D, 6);
    frame(1, 0, 0, 0, 0, 1, 8'h2E, 8'hD1, 24);
    frame(0, 1, 1, 1, 0, 1, 8'hC9, 8'h7B, 14);
    frame(0, 0, 0, 1, 0, 1, 8'h35, 8'hE4, 24);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule